// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a byte-oriented SPI master that software drives through a small register port. Bytes written to the transmit data register go into a transmit FIFO. The shifter takes them out one at a time and sends each one MSB first on `mosi`. The byte received on `miso` during each transfer goes into a receive FIFO, and software pops it by reading the receive data register. The serial clock runs at a fixed rate. Its half-period is `CLK_DIV` system clocks, and software cannot change it. Clock polarity and phase are selectable, so all four SPI modes are available.

A hold bit in the control word keeps the shifter idle while software fills the transmit FIFO. Clearing the hold bit releases the whole queue. The select lines are active low. In automatic mode they carry the select register only while a byte is shifting. In manual mode they follow the select register at all times, so a slave stays selected across any number of bytes. When the last queued byte completes and the transmit FIFO is empty, the block emits a one-cycle event for an interrupt controller.

Top module: `spi_reg_master`

## Requirements
- R1: After reset, the control word reads 0x100 (hold set) and status reads 0x05. `ss_n` is all ones, `sclk` is low and `tx_empty_evt` is low.
- R2: Register addresses are 0 control, 1 status, 2 transmit data, 3 receive data and 4 select. A new byte starts only when control bit 1 (enable) and bit 2 (master) are both set, bit 8 (hold) is clear and the transmit FIFO is not empty.
- R3: While control bit 8 is set, no `sclk` edge occurs and no select line is asserted, even when bytes are queued. Clearing the bit starts shifting.
- R4: Control bit 3 sets the idle level of `sclk`. With bit 4 clear, data is valid before the first edge and is sampled on odd-numbered edges. With bit 4 set, data changes on odd-numbered edges and is sampled on even-numbered ones. Words are 8 bits, MSB first.
- R5: Each shifted byte puts exactly one received byte into the receive FIFO. If that FIFO is full, the new byte is lost. A read of address 3 pops the FIFO, and a read while it is empty returns 0 and pops nothing.
- R6: Status bits are: bit 0 receive empty, bit 1 receive full, bit 2 transmit empty, bit 3 transmit full, bit 4 mode fault (always 0).
- R7: A write to address 2 while the transmit FIFO holds `DEPTH` bytes is discarded.
- R8: Writing control bit 5 or bit 6 empties the transmit or receive FIFO on the next cycle. The bit reads 1 for exactly that one cycle and then clears by itself.
- R9: With control bit 7 clear, `ss_n` equals the select register while a byte is shifting and is all ones otherwise.
- R10: With control bit 7 set, `ss_n` follows the select register continuously and does not change between consecutive bytes.
- R11: `tx_empty_evt` pulses high for one cycle when a byte finishes and the transmit FIFO is empty. No pulse occurs while queued bytes are held.
- R12: Each `sclk` half-period lasts `CLK_DIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO when reading address 3) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SEL | Active-low slave selects |
| tx_empty_evt | output | 1 | One-cycle transmit-drained event |

## Verification
The bench builds the block with `DEPTH` = 4, `CLK_DIV` = 2 and `NUM_SEL` = 4. The shallow FIFO lets the bench reach the full and overflow boundaries of both queues with only a few bytes, including dropped writes and receive overrun. The short divider keeps each byte to a few dozen cycles, so all four clock modes, the half-period measurement and multi-byte runs in both select modes fit in a short run. Received data is the inverted looped-back transmit data, which exposes bit-order and sampling-edge errors.

// File: rtl/spi_reg_master.sv
module spi_reg_master #(
  parameter int DEPTH   = 16,
  parameter int CLK_DIV = 4,
  parameter int NUM_SEL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [2:0]         reg_addr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic [NUM_SEL-1:0] ss_n,
  output logic               tx_empty_evt
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_TXD = 3'd2,
                         A_RXD = 3'd3, A_SEL = 3'd4;

  logic [8:0]         ctrl_q;
  logic [NUM_SEL-1:0] sel_q;
  logic               unused_wdata;
  assign unused_wdata = ^reg_wdata[15:9];

  logic ctrl_wr, sel_wr;
  assign ctrl_wr = reg_wr && reg_addr == A_CTRL;
  assign sel_wr  = reg_wr && reg_addr == A_SEL;

  logic en, mst, cpol, cpha, tx_clr, rx_clr, manual, hold;
  assign en     = ctrl_q[1];
  assign mst    = ctrl_q[2];
  assign cpol   = ctrl_q[3];
  assign cpha   = ctrl_q[4];
  assign tx_clr = ctrl_q[5];
  assign rx_clr = ctrl_q[6];
  assign manual = ctrl_q[7];
  assign hold   = ctrl_q[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 9'h100;
      sel_q  <= '1;
    end else begin
      if (ctrl_wr)
        ctrl_q <= {reg_wdata[8:1], 1'b0};
      else if (tx_clr || rx_clr)
        ctrl_q[6:5] <= 2'b00;
      if (sel_wr)
        sel_q <= reg_wdata[NUM_SEL-1:0];
    end
  end

  // transmit queue
  logic [7:0]    tx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_empty, tx_full, tx_push, tx_pop;
  assign tx_empty = tx_cnt == '0;
  assign tx_full  = tx_cnt == CW'(DEPTH);
  assign tx_push  = reg_wr && reg_addr == A_TXD && !tx_full;

  // receive queue
  logic [7:0]    rx_mem [DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic          rx_empty, rx_full, rx_push, rx_pop;
  assign rx_empty = rx_cnt == '0;
  assign rx_full  = rx_cnt == CW'(DEPTH);
  assign rx_pop   = reg_rd && reg_addr == A_RXD && !rx_empty;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (tx_push && !tx_clr) tx_mem[tx_wp] <= reg_wdata[7:0];
    if (rx_push && !rx_clr) rx_mem[rx_wp] <= rx_sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= bump(tx_wp);
      if (tx_pop)  tx_rp <= bump(tx_rp);
      if (tx_push && !tx_pop)      tx_cnt <= tx_cnt + 1'b1;
      else if (tx_pop && !tx_push) tx_cnt <= tx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= bump(rx_wp);
      if (rx_pop)  rx_rp <= bump(rx_rp);
      if (rx_push && !rx_pop)      rx_cnt <= rx_cnt + 1'b1;
      else if (rx_pop && !rx_push) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  // shifter
  logic          busy, phase, mosi_q, evt_q;
  logic [DW-1:0] div_cnt;
  logic [4:0]    tick_cnt;
  logic [7:0]    tx_sr, rx_sr, tx_head;
  logic          tick, done, load, go, lead, samp;

  assign tx_head = tx_mem[tx_rp];
  assign go      = en && mst && !hold && !tx_empty && !tx_clr;
  assign tick    = busy && div_cnt == DW'(CLK_DIV - 1);
  assign done    = tick && tick_cnt == 5'd16;
  assign load    = go && (!busy || done);
  assign tx_pop  = load;
  assign rx_push = done && !rx_full;
  assign lead    = !tick_cnt[0];
  assign samp    = lead ^ cpha;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; phase <= 1'b0; mosi_q <= 1'b0;
      div_cnt <= '0; tick_cnt <= '0; tx_sr <= '0; rx_sr <= '0;
    end else if (load) begin
      busy <= 1'b1; phase <= 1'b0; div_cnt <= '0; tick_cnt <= '0;
      if (!cpha) begin
        mosi_q <= tx_head[7];
        tx_sr  <= {tx_head[6:0], 1'b0};
      end else begin
        tx_sr  <= tx_head;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) begin
        tick_cnt <= tick_cnt + 1'b1;
        phase    <= ~phase;
        if (samp)
          rx_sr <= {rx_sr[6:0], miso};
        else if (cpha || tick_cnt != 5'd15) begin
          mosi_q <= tx_sr[7];
          tx_sr  <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= done && tx_empty;
  end

  assign sclk         = cpol ^ phase;
  assign mosi         = mosi_q;
  assign ss_n         = (manual || busy) ? sel_q : '1;
  assign tx_empty_evt = evt_q;

  logic [4:0] stat;
  assign stat = {1'b0, tx_full, tx_empty, rx_full, rx_empty};

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {7'b0, ctrl_q};
      A_STAT:  reg_rdata = {11'b0, stat};
      A_RXD:   reg_rdata = rx_empty ? 16'h0 : {8'h0, rx_mem[rx_rp]};
      A_SEL:   reg_rdata = 16'(sel_q);
      default: reg_rdata = 16'h0;
    endcase
  end
endmodule

module spi_reg_master_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       busy,
  input logic                       hold,
  input logic                       evt,
  input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
  input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
  input logic                       txrst,
  input logic                       txrst_wr,
  input logic                       sclk,
  input logic                       cpol
);
  localparam int CW = $clog2(DEPTH + 1);

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !busy) |=> !busy);
  // R11
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
  // R11
  evt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> !busy);
  // R7
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));
  // R5
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));
  // R8
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txrst && !txrst_wr) |=> !txrst);
  // R4
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $stable(cpol)) |-> $stable(sclk));
endmodule

bind spi_reg_master spi_reg_master_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .hold(ctrl_q[8]),
  .evt(tx_empty_evt), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .txrst(ctrl_q[5]), .txrst_wr(ctrl_wr && reg_wdata[5]),
  .sclk(sclk), .cpol(ctrl_q[3])
);

// File: tb/spi_reg_master_test.sv
module spi_reg_master_test;
  localparam int DEPTH = 4, CLK_DIV = 2, NSEL = 4;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic sclk, mosi, miso, evt;
  logic [NSEL-1:0] ss_n;

  assign miso = ~mosi;

  spi_reg_master #(.DEPTH(DEPTH), .CLK_DIV(CLK_DIV), .NUM_SEL(NSEL)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .tx_empty_evt(evt));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  int evt_cnt = 0, edge_cnt = 0;
  bit mon_on = 0, m_cpol = 0, m_cpha = 0, ss_watch = 0, ss_moved = 0;
  int mon_bits = 0, mon_n = 0;
  logic [7:0] mon_sr;
  logic [7:0] mon_byte [16];

  always @(negedge clk) if (evt) evt_cnt++;
  always @(sclk) begin
    edge_cnt++;
    if (mon_on && (sclk ^ m_cpol ^ m_cpha)) begin
      mon_sr = {mon_sr[6:0], mosi};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_byte[mon_n] = mon_sr;
        mon_n++;
        mon_bits = 0;
      end
    end
  end
  always @(ss_n) if (ss_watch) ss_moved = 1;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0; reg_addr = 0;
  endtask

  task automatic wait_evt(input int lim, input string tag);
    int e0 = evt_cnt;
    int n = 0;
    while (evt_cnt == e0 && n < lim) begin @(negedge clk); n++; end
    chk(tag, int'(evt_cnt != e0), 1);
  endtask

  function automatic logic [15:0] cw(input bit inh, input bit cp, input bit ph);
    return {7'b0, inh, 3'b000, ph, cp, 3'b110};
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    rd(0, v); chk("R1 control reset", v, 16'h100);
    rd(1, v); chk("R1 status reset", v, 16'h05);
    chk("R1 select idle", ss_n, 4'hF);
    chk("R1 sclk low", sclk, 0);
    chk("R1 event low", evt, 0);
  endtask

  task automatic t_hold();
    logic [15:0] v;
    m_cpol = 0; m_cpha = 0;
    wr(0, 16'h106);
    wr(4, 16'h000D);
    wr(2, 16'h00A5); wr(2, 16'h003C);
    edge_cnt = 0;
    repeat (60) @(negedge clk);
    chk("R3 no edges while held", edge_cnt, 0);
    chk("R3 no select while held", ss_n, 4'hF);
    chk("R11 no event while held", evt_cnt, 0);
    rd(1, v); chk("R6 status two queued", v, 16'h01);
    mon_n = 0; mon_bits = 0; mon_on = 1;
    wr(0, 16'h006);
    repeat (6) @(negedge clk);
    chk("R9 auto select while shifting", ss_n, 4'hD);
    wait_evt(500, "R11 event after drain");
    repeat (3) @(negedge clk);
    chk("R11 single pulse", evt_cnt, 1);
    chk("R9 deselect after", ss_n, 4'hF);
    chk("R4 byte count", mon_n, 2);
    chk("R4 first byte mode0", mon_byte[0], 8'hA5);
    chk("R4 second byte mode0", mon_byte[1], 8'h3C);
    mon_on = 0;
    rd(3, v); chk("R5 rx first", v, 16'h5A);
    rd(3, v); chk("R5 rx second", v, 16'hC3);
    rd(3, v); chk("R5 empty read zero", v, 16'h00);
    rd(1, v); chk("R5 empty read no pop", v, 16'h05);
  endtask

  task automatic t_gate();
    logic [15:0] v;
    wr(0, 16'h004);
    wr(2, 16'h0011);
    edge_cnt = 0;
    repeat (50) @(negedge clk);
    chk("R2 no start without enable", edge_cnt, 0);
    wr(0, 16'h002);
    repeat (50) @(negedge clk);
    chk("R2 no start without master", edge_cnt, 0);
    rd(1, v); chk("R2 byte still queued", v, 16'h01);
    wr(0, 16'h124);
    rd(1, v); chk("R8 tx cleared", v, 16'h05);
  endtask

  task automatic t_mode(input bit cp, input bit ph, input logic [7:0] b);
    logic [15:0] v;
    int n;
    mon_on = 0; m_cpol = cp; m_cpha = ph;
    wr(0, cw(1, cp, ph));
    repeat (2) @(negedge clk);
    chk("R4 idle level", sclk, cp);
    mon_n = 0; mon_bits = 0; mon_on = 1;
    wr(2, {8'h0, b});
    wr(0, cw(0, cp, ph));
    n = 0;
    while (sclk == cp && n < 100) begin @(negedge clk); n++; end
    n = 0;
    while (sclk != cp && n < 100) begin @(negedge clk); n++; end
    chk("R12 half period", n, CLK_DIV);
    wait_evt(500, "R11 mode event");
    chk("R4 mode byte count", mon_n, 1);
    chk("R4 mode byte", mon_byte[0], b);
    chk("R4 idle after byte", sclk, cp);
    mon_on = 0;
    rd(3, v); chk("R5 mode rx", v, {8'h0, ~b});
  endtask

  task automatic t_full();
    logic [15:0] v;
    m_cpol = 0; m_cpha = 0;
    wr(0, 16'h106);
    for (int i = 0; i < DEPTH + 2; i++) wr(2, 16'h10 + 16'(i));
    rd(1, v); chk("R6 tx full status", v, 16'h09);
    mon_n = 0; mon_bits = 0; mon_on = 1;
    wr(0, 16'h006);
    wait_evt(800, "R7 event after full run");
    chk("R7 extra writes dropped", mon_n, DEPTH);
    chk("R7 last sent byte", mon_byte[DEPTH-1], 8'h13);
    rd(1, v); chk("R6 rx full status", v, 16'h06);
    wr(2, 16'h0020);
    wait_evt(500, "R5 overrun byte sent");
    mon_on = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rd(3, v); chk("R5 overrun keeps old", v, {8'h0, ~(8'h10 + 8'(i))});
    end
    rd(1, v); chk("R5 overrun byte lost", v, 16'h05);
  endtask

  task automatic t_reset_bits();
    logic [15:0] v;
    wr(0, 16'h106);
    wr(2, 16'h0001); wr(2, 16'h0002);
    wr(0, 16'h126);
    #1 chk("R8 tx reset bit visible", reg_rdata[5], 1);
    rd(0, v); chk("R8 tx reset self clear", v, 16'h106);
    rd(1, v); chk("R8 tx fifo emptied", v, 16'h05);
    wr(2, 16'h0003);
    wr(0, 16'h006);
    wait_evt(500, "R8 rx fill");
    rd(1, v); chk("R6 rx one byte", v, 16'h04);
    wr(0, 16'h146);
    rd(0, v); chk("R8 rx reset self clear", v, 16'h106);
    rd(1, v); chk("R8 rx fifo emptied", v, 16'h05);
  endtask

  task automatic t_manual();
    m_cpol = 0; m_cpha = 0;
    wr(0, 16'h186);
    wr(4, 16'h000B);
    repeat (2) @(negedge clk);
    chk("R10 manual select idle", ss_n, 4'hB);
    wr(2, 16'h0081); wr(2, 16'h007E);
    mon_n = 0; mon_bits = 0; mon_on = 1;
    ss_moved = 0; ss_watch = 1;
    wr(0, 16'h086);
    wait_evt(500, "R10 manual run");
    ss_watch = 0; mon_on = 0;
    chk("R10 select steady", ss_moved, 0);
    chk("R10 select held", ss_n, 4'hB);
    chk("R10 bytes sent", mon_n, 2);
    chk("R10 second byte", mon_byte[1], 8'h7E);
    wr(4, 16'h000F);
    repeat (1) @(negedge clk);
    chk("R10 deselect by register", ss_n, 4'hF);
    wr(0, 16'h146);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_hold();
    t_gate();
    t_mode(0, 0, 8'hC9);
    t_mode(0, 1, 8'h35);
    t_mode(1, 0, 8'h96);
    t_mode(1, 1, 8'h4E);
    t_full();
    t_reset_bits();
    t_manual();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule